// File: doc/BRIEF.md
# SPI Byte-Addressed Memory Slave

This block is the serial front end of a 512-byte memory. A host drives a four-wire SPI bus plus an active-low hold line. Every chip-select window carries exactly one command byte. Depending on that command, the block then reads one address byte and any number of data bytes, returns a status byte, takes a status byte, or does nothing more. Writes land in the memory one byte at a time, as soon as the eighth bit of each byte arrives. There is no page buffer and no busy flag. Reads prefetch each byte from a synchronous memory port so that its first bit is ready at the next falling clock edge.

The block runs on a fast system clock, and the SPI pins are treated as slow signals sampled by it. The pins are assumed to be synchronised already, and SCK must stay high and low for at least four system clocks each. The block keeps a write-enable latch and two protection bits. An external protection stage reads the protection bits from `prot_bits`. It returns a single permission signal, `wr_allow`, which must be high for a memory or status write to take effect. The memory array itself lives outside the block and is reached through the `mem_*` port.

Top module: `spi_byte_mem`

## Requirements
- R1: Bytes move MSB first. SI is taken on each rising SCK edge, and SO changes only after a falling SCK edge. The bus works in both clock polarities where data is captured on the rising edge: SCK idle low and SCK idle high.
- R2: The command byte is decoded as follows. 0x06 sets the write latch and 0x04 clears it. 0x05 reads the status byte and 0x01 writes it. A byte of the form 0000_x011 starts a read and 0000_x010 starts a write; in both, bit 3 (x) is memory address bit 8.
- R3: After a read or write command, the next byte gives address bits 7..0. It is joined with the bit 8 taken from the command to form a 9-bit start address.
- R4: After each data byte the address advances by one, and it wraps from 0x1FF to 0x000. A burst may run for any number of bytes, in both the read and the write direction.
- R5: After the eighth bit of each write data byte, `mem_we` pulses for one system clock, carrying that byte and its address. This happens only when the write latch is set and `wr_allow` is high. In every other case memory is left untouched.
- R6: The write latch is 0 after reset. Command 0x06 sets it. Command 0x04 clears it, and so does the end of any chip-select window that carried a read-free write command (memory write or status write).
- R7: The status byte reads as {0000, P1, P0, WEL, 0}, where P1 and P0 are the protection bits and WEL is the write latch. A status write changes only P1 and P0, taking them from bits 3..2 of the data byte, and only when the write latch and `wr_allow` are both high. `prot_bits` always shows {P1, P0}.
- R8: Only the first byte of a chip-select window is decoded as a command. Every later byte of a no-data command (0x06 or 0x04) is ignored. An undefined command makes the block ignore the rest of the window.
- R9: `spi_so_oe` is high only while read data or the single status byte is being shifted out. It is low during the command and address bytes, after the status byte, and while CS is high.
- R10: While HOLD is low, SCK edges are ignored and `spi_so_oe` is low. When HOLD returns high, the transfer resumes from the bit where it stopped.
- R11: CS high returns the block to waiting for a command, and any partly received byte is discarded.
- R12: After reset, SO is disabled, no memory access is issued, and the protection bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock (synchronised) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_hold_n | input | 1 | Hold, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so |
| wr_allow | input | 1 | Write permission from the protection stage |
| prot_bits | output | 2 | Stored protection bits P1,P0 |
| mem_addr | output | 9 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe; data is expected on mem_rdata one clock later |
| mem_rdata | input | 8 | Memory read data |

## Verification
The bench goes after the wrap from 0x1FF to 0x000 within a single burst, in both directions. A design with a narrow counter or a saturating address would write or read the wrong second byte. It also uses the command bit that carries address bit 8: if that bit were dropped, writes to the upper half of memory would land on the lower half and readback would give the wrong value. Permission gating is checked after a missing enable command, with `wr_allow` low, and after the latch has cleared at the end of a write; a design that kept the latch set would let a second, unenabled write through. The bench also checks that trailing bytes after a command, bytes after an undefined command, and a hold in the middle of a read byte change nothing: a design that re-decoded those bytes or counted edges during hold would corrupt state or the data shifted out.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam logic [DATA_W-1:0] CMD_LATCH_SET = 8'h06;
  localparam logic [DATA_W-1:0] CMD_LATCH_CLR = 8'h04;
  localparam logic [DATA_W-1:0] CMD_STAT_RD   = 8'h05;
  localparam logic [DATA_W-1:0] CMD_STAT_WR   = 8'h01;
  localparam logic [2:0]        CMD_MEM_RD_LO = 3'b011;
  localparam logic [2:0]        CMD_MEM_WR_LO = 3'b010;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_STAT_IN,
    PH_STAT_OUT,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_mem_edge.sv
module spi_mem_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic rise,
  output logic fall,
  output logic term
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  // Edges count only while selected and not held.
  assign rise = sck & ~sck_q & ~cs_n & hold_n;
  assign fall = ~sck & sck_q & ~cs_n & hold_n;
  assign term = cs_n & hold_n;
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              term,
  input  logic              si,
  input  logic              wr_allow,
  output phase_t            phase,
  output logic [CNT_W-1:0]  bitcnt,
  output logic [DATA_W-1:0] status,
  output logic              stat_load,
  output logic [1:0]        prot,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re
);
  logic [DATA_W-2:0] sr;
  logic [ADDR_W-1:0] addr;
  logic              a_hi;
  logic              is_rd;
  logic              wr_op;
  logic              wel;
  logic              byte_done;
  logic [DATA_W-1:0] byte_in;
  logic              cmd_rd;
  logic              cmd_wr;

  assign byte_done = rise && (bitcnt == CNT_W'(DATA_W-1));
  assign byte_in   = {sr, si};
  assign cmd_rd    = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == CMD_MEM_RD_LO);
  assign cmd_wr    = (byte_in[7:4] == 4'h0) && (byte_in[2:0] == CMD_MEM_WR_LO);
  assign status    = {4'h0, prot, wel, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      bitcnt    <= '0;
      sr        <= '0;
      addr      <= '0;
      a_hi      <= 1'b0;
      is_rd     <= 1'b0;
      wr_op     <= 1'b0;
      wel       <= 1'b0;
      prot      <= 2'b00;
      stat_load <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      mem_re    <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      stat_load <= 1'b0;
      if (term) begin
        phase  <= PH_CMD;
        bitcnt <= '0;
        if (wr_op) wel <= 1'b0;
        wr_op  <= 1'b0;
      end else if (rise) begin
        bitcnt <= bitcnt + 1'b1;
        sr     <= byte_in[DATA_W-2:0];
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              if (byte_in == CMD_LATCH_SET) begin
                wel   <= 1'b1;
                phase <= PH_SKIP;
              end else if (byte_in == CMD_LATCH_CLR) begin
                wel   <= 1'b0;
                phase <= PH_SKIP;
              end else if (byte_in == CMD_STAT_RD) begin
                stat_load <= 1'b1;
                phase     <= PH_STAT_OUT;
              end else if (byte_in == CMD_STAT_WR) begin
                wr_op <= 1'b1;
                phase <= PH_STAT_IN;
              end else if (cmd_rd) begin
                a_hi  <= byte_in[3];
                is_rd <= 1'b1;
                phase <= PH_ADDR;
              end else if (cmd_wr) begin
                a_hi  <= byte_in[3];
                is_rd <= 1'b0;
                wr_op <= 1'b1;
                phase <= PH_ADDR;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_ADDR: begin
              addr <= {a_hi, byte_in};
              if (is_rd) begin
                mem_addr <= {a_hi, byte_in};
                mem_re   <= 1'b1;
                phase    <= PH_RDATA;
              end else begin
                phase    <= PH_WDATA;
              end
            end
            PH_WDATA: begin
              if (wel && wr_allow) begin
                mem_we    <= 1'b1;
                mem_addr  <= addr;
                mem_wdata <= byte_in;
              end
              addr <= addr + 1'b1;
            end
            PH_RDATA: begin
              addr     <= addr + 1'b1;
              mem_addr <= addr + 1'b1;
              mem_re   <= 1'b1;
            end
            PH_STAT_IN: begin
              if (wel && wr_allow) prot <= byte_in[3:2];
              phase <= PH_SKIP;
            end
            PH_STAT_OUT: phase <= PH_SKIP;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_tx.sv
module spi_mem_tx
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              term,
  input  logic              cs_n,
  input  logic              hold_n,
  input  phase_t            phase,
  input  logic [CNT_W-1:0]  bitcnt,
  input  logic [DATA_W-1:0] status,
  input  logic              stat_load,
  input  logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              so,
  output logic              so_oe
);
  logic [DATA_W-1:0] tx_byte;
  logic              re_q;
  logic              drive;
  logic              out_phase;
  logic [CNT_W-1:0]  bit_sel;

  assign out_phase = (phase == PH_RDATA) || (phase == PH_STAT_OUT);
  assign bit_sel   = CNT_W'(DATA_W-1) - bitcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_byte <= '0;
      re_q    <= 1'b0;
      drive   <= 1'b0;
      so      <= 1'b0;
      so_oe   <= 1'b0;
    end else begin
      re_q <= mem_re;
      if (stat_load) tx_byte <= status;
      else if (re_q) tx_byte <= mem_rdata;
      if (term) begin
        drive <= 1'b0;
      end else if (fall) begin
        drive <= out_phase;
        if (out_phase) so <= tx_byte[bit_sel];
      end
      so_oe <= drive & ~cs_n & hold_n;
    end
  end
endmodule

// File: rtl/spi_byte_mem.sv
module spi_byte_mem
  import spi_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_hold_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              wr_allow,
  output logic [1:0]        prot_bits,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              rise;
  logic              fall;
  logic              term;
  phase_t            phase;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] status;
  logic              stat_load;

  spi_mem_edge u_edge (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .hold_n(spi_hold_n),
    .rise(rise), .fall(fall), .term(term)
  );

  spi_mem_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rise(rise), .term(term), .si(spi_si),
    .wr_allow(wr_allow), .phase(phase), .bitcnt(bitcnt), .status(status),
    .stat_load(stat_load), .prot(prot_bits), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re)
  );

  spi_mem_tx u_tx (
    .clk(clk), .rst(rst), .fall(fall), .term(term), .cs_n(spi_cs_n),
    .hold_n(spi_hold_n), .phase(phase), .bitcnt(bitcnt), .status(status),
    .stat_load(stat_load), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .so(spi_so), .so_oe(spi_so_oe)
  );
endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk (
  input logic       clk,
  input logic       rst,
  input logic       spi_cs_n,
  input logic       spi_hold_n,
  input logic       spi_so_oe,
  input logic [1:0] prot_bits,
  input logic       mem_we,
  input logic       mem_re
);
  // R5: a commit strobe lasts exactly one clock
  assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R5: a byte is never read and written in the same clock
  assert_we_re_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R9: deselect turns the output driver off
  assert_oe_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |=> !spi_so_oe);

  // R10: hold turns the output driver off
  assert_oe_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !spi_hold_n |=> !spi_so_oe);

  // R10: no commit can follow a held clock
  assert_no_we_hold_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!spi_hold_n) |-> !mem_we);

  // R11: nothing is committed or changed while deselected
  assert_no_we_idle_R11: assert property (@(posedge clk) disable iff (rst)
    $past(spi_cs_n) |-> !mem_we);

  // R7: protection bits only change inside a selected window
  assert_prot_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $past(spi_cs_n) |-> $stable(prot_bits));
endmodule

bind spi_byte_mem spi_mem_chk u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_hold_n(spi_hold_n),
  .spi_so_oe(spi_so_oe), .prot_bits(prot_bits), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/spi_byte_mem_tb.sv
module spi_byte_mem_tb;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       hold_n = 1'b1;
  logic       si = 1'b0;
  logic       so, so_oe;
  logic       wr_allow = 1'b1;
  logic [1:0] prot;
  logic [8:0] maddr;
  logic       mwe, mre;
  logic [7:0] mwdata;
  logic [7:0] mrdata;
  logic [7:0] mem [512];
  int         errors = 0;
  int         checks = 0;
  int         we_cnt = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  spi_byte_mem u_dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_hold_n(hold_n),
    .spi_si(si), .spi_so(so), .spi_so_oe(so_oe), .wr_allow(wr_allow),
    .prot_bits(prot), .mem_addr(maddr), .mem_we(mwe), .mem_wdata(mwdata),
    .mem_re(mre), .mem_rdata(mrdata)
  );

  initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;

  always_ff @(posedge clk) begin
    if (mwe) begin
      mem[maddr] <= mwdata;
      we_cnt     <= we_cnt + 1;
    end
    if (mre) mrdata <= mem[maddr];
  end

  typedef struct packed {
    logic       m3;
    logic [8:0] a;
    logic [7:0] d;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 9'h000, 8'h11},
    '{1'b1, 9'h100, 8'hE2},
    '{1'b0, 9'h0FF, 8'h3C},
    '{1'b1, 9'h1FE, 8'h81},
    '{1'b0, 9'h080, 8'h5A},
    '{1'b1, 9'h17F, 8'hC7}
  };

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_start(input bit m3);
    sck  = m3;
    half();
    cs_n = 1'b0;
    half();
  endtask

  task automatic cs_end(input bit m3);
    sck  = m3;
    half();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic xbit(input bit b, output bit r, output bit oe);
    sck = 1'b0;
    si  = b;
    half();
    r   = so;
    oe  = so_oe;
    sck = 1'b1;
    half();
  endtask

  task automatic xbyte(input logic [7:0] tx, input bit m3,
                       output logic [7:0] rx, output bit oe_any, output bit oe_all);
    bit r, oe;
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      xbit(tx[i], r, oe);
      rx[i]  = r;
      oe_any = oe_any | oe;
      oe_all = oe_all & oe;
    end
    if (!m3) begin
      sck = 1'b0;
      half();
    end
  endtask

  task automatic t_cmd(input logic [7:0] op, input bit m3);
    logic [7:0] rx;
    bit oa, ol;
    cs_start(m3);
    xbyte(op, m3, rx, oa, ol);
    cs_end(m3);
  endtask

  task automatic t_rdsr(input bit m3, output logic [7:0] st, output bit oe_ok);
    logic [7:0] rx;
    bit oa, ol, oa2, ol2;
    cs_start(m3);
    xbyte(8'h05, m3, rx, oa, ol);
    xbyte(8'h00, m3, st, oa2, ol2);
    oe_ok = !oa && ol2;
    cs_end(m3);
  endtask

  task automatic t_write(input bit m3, input logic [8:0] a, input int n,
                         input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] rx;
    bit oa, ol;
    cs_start(m3);
    xbyte({4'h0, a[8], 3'b010}, m3, rx, oa, ol);
    xbyte(a[7:0], m3, rx, oa, ol);
    xbyte(d0, m3, rx, oa, ol);
    if (n > 1) xbyte(d1, m3, rx, oa, ol);
    cs_end(m3);
  endtask

  task automatic t_read(input bit m3, input logic [8:0] a, input int n,
                        output logic [7:0] q0, output logic [7:0] q1,
                        output bit hdr_oe, output bit dat_oe);
    logic [7:0] rx;
    bit oa1, ol1, oa2, ol2, oa, ol;
    cs_start(m3);
    xbyte({4'h0, a[8], 3'b011}, m3, rx, oa1, ol1);
    xbyte(a[7:0], m3, rx, oa2, ol2);
    xbyte(8'hFF, m3, q0, oa, ol);
    dat_oe = ol;
    q1 = 8'h00;
    if (n > 1) begin
      xbyte(8'h00, m3, q1, oa, ol);
      dat_oe = dat_oe & ol;
    end
    hdr_oe = oa1 | oa2;
    cs_end(m3);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, q0, q1, rx;
    bit ok, hoe, doe, oa, ol, r, oe;
    int w0;

    repeat (4) @(negedge clk);
    // R12: reset state
    check("R12 so_oe after reset", so_oe, 0);
    check("R12 mem_we after reset", mwe, 0);
    check("R12 prot after reset", prot, 0);
    rst = 1'b0;
    half();
    t_rdsr(1'b0, st, ok);
    check("R6 R12 status after reset", st, 8'h00);
    check("R9 status byte enable window", ok, 1);

    // Vector table: enable, write one byte, read it back, status cleared (R1-R6)
    foreach (VEC[k]) begin
      t_cmd(8'h06, VEC[k].m3);
      t_write(VEC[k].m3, VEC[k].a, 1, VEC[k].d, 8'h00);
      t_read(VEC[k].m3, VEC[k].a, 1, q0, q1, hoe, doe);
      check("R1 R2 R3 readback", q0, VEC[k].d);
      check("R9 no drive in header", hoe, 0);
      check("R9 drive in data", doe, 1);
      check("R5 memory model", mem[VEC[k].a], VEC[k].d);
      t_rdsr(VEC[k].m3, st, ok);
      check("R6 latch cleared after write", st, 8'h00);
    end

    // R2 R3: upper-half address kept apart from lower half
    check("R2 bit8 upper", mem[9'h100], 8'hE2);
    check("R2 bit8 lower", mem[9'h000], 8'h11);

    // R4: burst wraps across 0x1FF
    t_cmd(8'h06, 1'b0);
    t_write(1'b0, 9'h1FF, 2, 8'hA5, 8'h5A);
    check("R4 write wrap top", mem[9'h1FF], 8'hA5);
    check("R4 write wrap zero", mem[9'h000], 8'h5A);
    t_read(1'b1, 9'h1FF, 2, q0, q1, hoe, doe);
    check("R4 read wrap first", q0, 8'hA5);
    check("R4 read wrap second", q1, 8'h5A);

    // R5: no enable means no write
    w0 = we_cnt;
    t_write(1'b0, 9'h033, 1, 8'hEE, 8'h00);
    check("R5 write without latch", we_cnt - w0, 0);
    t_read(1'b0, 9'h033, 1, q0, q1, hoe, doe);
    check("R5 memory untouched", q0, 8'h00);

    // R5: permission low blocks the write; latch still cleared
    wr_allow = 1'b0;
    t_cmd(8'h06, 1'b0);
    t_write(1'b0, 9'h034, 1, 8'h77, 8'h00);
    check("R5 write blocked by permission", we_cnt - w0, 0);
    t_rdsr(1'b0, st, ok);
    check("R6 latch cleared after blocked write", st, 8'h00);
    t_cmd(8'h06, 1'b0);
    t_cmd(8'h01, 1'b0);
    cs_start(1'b0);
    xbyte(8'h01, 1'b0, rx, oa, ol);
    xbyte(8'hFF, 1'b0, rx, oa, ol);
    cs_end(1'b0);
    check("R7 status write blocked", prot, 0);
    wr_allow = 1'b1;

    // R7: status write changes only the protection bits
    t_cmd(8'h06, 1'b1);
    cs_start(1'b1);
    xbyte(8'h01, 1'b1, rx, oa, ol);
    xbyte(8'hFF, 1'b1, rx, oa, ol);
    cs_end(1'b1);
    check("R7 prot output", prot, 2'b11);
    t_rdsr(1'b1, st, ok);
    check("R7 status layout", st, 8'h0C);
    t_cmd(8'h06, 1'b0);
    t_rdsr(1'b0, st, ok);
    check("R6 R7 latch in status", st, 8'h0E);
    cs_start(1'b0);
    xbyte(8'h01, 1'b0, rx, oa, ol);
    xbyte(8'h00, 1'b0, rx, oa, ol);
    cs_end(1'b0);
    check("R7 prot cleared", prot, 2'b00);

    // R8: one command per window
    t_cmd(8'h06, 1'b0);
    cs_start(1'b0);
    xbyte(8'h04, 1'b0, rx, oa, ol);
    xbyte(8'h06, 1'b0, rx, oa, ol);
    xbyte(8'h05, 1'b0, rx, oa, ol);
    cs_end(1'b0);
    check("R8 trailing bytes no drive", oa, 0);
    t_rdsr(1'b0, st, ok);
    check("R8 trailing set ignored", st, 8'h00);

    // R8: undefined command swallows the window
    w0 = we_cnt;
    cs_start(1'b0);
    xbyte(8'h0C, 1'b0, rx, oa, ol);
    xbyte(8'h06, 1'b0, rx, oa, ol);
    xbyte(8'h02, 1'b0, rx, oa, ol);
    cs_end(1'b0);
    check("R8 undefined no drive", oa, 0);
    t_rdsr(1'b0, st, ok);
    check("R8 undefined then set ignored", st, 8'h00);
    check("R8 undefined no write", we_cnt - w0, 0);

    // R11: partial byte discarded by deselect
    cs_start(1'b0);
    for (int i = 0; i < 3; i++) xbit(1'b1, r, oe);
    cs_end(1'b0);
    t_cmd(8'h06, 1'b0);
    t_rdsr(1'b0, st, ok);
    check("R11 reframe after partial byte", st, 8'h02);
    t_cmd(8'h04, 1'b0);
    t_rdsr(1'b0, st, ok);
    check("R6 clear command", st, 8'h00);

    // R10: hold in the middle of a read byte
    t_cmd(8'h06, 1'b0);
    t_write(1'b0, 9'h040, 2, 8'hC3, 8'h96);
    cs_start(1'b0);
    xbyte(8'h03, 1'b0, rx, oa, ol);
    xbyte(8'h40, 1'b0, rx, oa, ol);
    for (int i = 7; i >= 4; i--) begin
      xbit(1'b0, r, oe);
      q0[i] = r;
    end
    sck = 1'b0;
    half();
    hold_n = 1'b0;
    half();
    check("R10 output off in hold", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; half();
      sck = 1'b0; half();
    end
    hold_n = 1'b1;
    half();
    for (int i = 3; i >= 0; i--) begin
      xbit(1'b0, r, oe);
      q0[i] = r;
    end
    sck = 1'b0;
    half();
    xbyte(8'h00, 1'b0, q1, oa, ol);
    cs_end(1'b0);
    check("R10 byte across hold", q0, 8'hC3);
    check("R10 R4 next byte after hold", q1, 8'h96);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule